// File: doc/BRIEF.md
# Secondary Bus Two-Tier Arbiter

This block decides which master owns the secondary side of a bus-to-bus bridge. Seven clients compete for the bus. Client 0 is the bridge's own master port, and clients 1 to 6 are external masters. Requests and grants are active-low, as on a PCI bus. Requests and the bus-idle condition are registered before the grant decision, and the grants come straight from flops. At most one grant is low in any cycle.

Configuration bits per client place each client in a high or a low priority class, or mask it out. Each class rotates round-robin, starting after the last client that class granted. The low class as a whole fills one extra slot in the high rotation, so low clients are served once per high round. A grant moves only when its holder releases its request or when the bus is sampled idle. With no unmasked request, the grant parks on client 0.

When the arbiter enable input is low, every grant is driven high. The bridge's own request is then passed out to an external arbiter, and the bridge's grant comes from that arbiter. All pins are level control signals with no handshake.

Top module: `sec_bus_arbiter`

## Requirements
- R1: While reset is low, every grant output is high. On the first rising edge after reset is released with the enable high, the grant parks on client 0, so `gnt_n` reads 7'b1111110.
- R2: Requests are registered once, so a request change shows in the grants on the second rising edge after it is driven and not on the first.
- R3: At most one bit of `gnt_n` is low in any cycle.
- R4: Among high-class clients, the winner is the first requesting high client found after the last high client granted, in ascending index order with wrap-around. After reset the search starts at client 0.
- R5: The low class takes slot index 7 in the high rotation, after client 6. When that slot wins, the low winner is the first requesting low client after the last low client granted. After reset the low search starts at client 0.
- R6: While the holder keeps its request low and the bus is not sampled idle, the grant does not change.
- R7: The bus counts as idle only when `frame_n` and `irdy_n` are both sampled high. In an idle cycle the grant may pass to another client even though the holder is still requesting. One of the two signals high on its own does not allow a handover.
- R8: When the arbiter is enabled and there is no unmasked request, the grant rests on client 0. Once enabled, a grant is always present.
- R9: A client whose `cfg_mask` bit is 1 has its request ignored, and it is never granted through that request. Parking on client 0 is the only case where a masked client holds the grant.
- R10: A change to `cfg_hi` or `cfg_mask` applies only at the next handover. It never removes the grant from a holder that is still requesting on a busy bus.
- R11: With `arb_en` low, all of `gnt_n` is high from the next rising edge. `ext_req_n` follows `req_n[0]`, and `host_gnt_n` follows `ext_gnt_n`, both without delay. With `arb_en` high, `ext_req_n` is 1 and `host_gnt_n` equals `gnt_n[0]`. On re-enable, a decision is made on the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_en | input | 1 | Internal arbiter enable. Low hands control to an external arbiter |
| req_n | input | 7 | Per-client bus request, active low. Bit 0 is the bridge's own master port |
| frame_n | input | 1 | Bus frame signal, active low |
| irdy_n | input | 1 | Bus initiator-ready signal, active low |
| cfg_hi | input | 7 | Per-client class select: 1 places the client in the high class, 0 in the low class |
| cfg_mask | input | 7 | Per-client mask: 1 ignores that client's request |
| ext_gnt_n | input | 1 | Grant from an external arbiter for the bridge's own port |
| gnt_n | output | 7 | Per-client grant, active low, registered |
| ext_req_n | output | 1 | Bridge's own request passed to an external arbiter |
| host_gnt_n | output | 1 | Grant seen by the bridge's own master port |

## Verification
A corrupted rotation pointer does not change the current grant. It shows at the next handover, two clock edges after the holder lets go of its request, as a grant to a requester other than the expected next one, and the bench checks that client against hand-worked rotation sequences. A corrupted grant register shows at once, either as two low grant bits or as a silent bus with the arbiter enabled. A broken sampling stage moves every grant change one edge early or late. A broken handover condition shows as a grant taken from a requesting holder on a busy bus, or kept through an idle cycle.

// File: rtl/sec_arb_pkg.sv
package sec_arb_pkg;

  // Client count used as the default everywhere
  localparam int unsigned ARB_CLIENTS_DFLT = 7;

  // Which tier produced the current decision
  typedef enum logic [1:0] {
    TIER_NONE = 2'd0,
    TIER_HI   = 2'd1,
    TIER_LO   = 2'd2
  } tier_e;

endpackage

// File: rtl/sec_arb_rr_pick.sv
// Rotating first-hit search: returns the first candidate after `last`.
module sec_arb_rr_pick #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]                        cand,
  input  logic [((WIDTH > 1) ? $clog2(WIDTH) : 1)-1:0] last,
  output logic                                    hit,
  output logic [((WIDTH > 1) ? $clog2(WIDTH) : 1)-1:0] pick
);
  localparam int unsigned IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [IW-1:0] slot;

  // Walk from the farthest slot to the nearest; the nearest hit is written last.
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    slot = '0;
    for (int k = WIDTH; k >= 1; k--) begin
      slot = IW'((int'(last) + k) % WIDTH);
      if (cand[slot]) begin
        hit  = 1'b1;
        pick = slot;
      end
    end
  end

endmodule

// File: rtl/sec_arb_sampler.sv
// Registers the requests and the bus-idle condition ahead of the decision.
module sec_arb_sampler #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_n,
  input  logic         frame_n,
  input  logic         irdy_n,
  output logic [N-1:0] req_q,
  output logic         idle_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      idle_q <= 1'b0;
    end else begin
      req_q  <= ~req_n;
      idle_q <= frame_n & irdy_n;
    end
  end

endmodule

// File: rtl/sec_arb_decide.sv
// Two-tier winner selection: high class rotation with one extra slot for the low group.
module sec_arb_decide
  import sec_arb_pkg::*;
#(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0]                          req_q,
  input  logic [N-1:0]                          cfg_hi,
  input  logic [N-1:0]                          cfg_mask,
  input  logic [$clog2(N+1)-1:0]                hi_ptr,
  input  logic [((N > 1) ? $clog2(N) : 1)-1:0]  lo_ptr,
  output tier_e                                 tier,
  output logic [$clog2(N+1)-1:0]                hi_pick,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0]  win
);
  localparam int unsigned SLOTS = N + 1;
  localparam int unsigned SIW   = $clog2(SLOTS);
  localparam int unsigned CIW   = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     eff_req;
  logic [N-1:0]     hi_req;
  logic [N-1:0]     lo_req;
  logic [SLOTS-1:0] slot_req;
  logic             hi_hit;
  logic             lo_hit;
  logic [CIW-1:0]   lo_pick;

  assign eff_req  = req_q & ~cfg_mask;
  assign hi_req   = eff_req & cfg_hi;
  assign lo_req   = eff_req & ~cfg_hi;
  assign slot_req = {|lo_req, hi_req};

  sec_arb_rr_pick #(.WIDTH(SLOTS)) u_hi_pick (
    .cand (slot_req),
    .last (hi_ptr),
    .hit  (hi_hit),
    .pick (hi_pick)
  );

  sec_arb_rr_pick #(.WIDTH(N)) u_lo_pick (
    .cand (lo_req),
    .last (lo_ptr),
    .hit  (lo_hit),
    .pick (lo_pick)
  );

  always_comb begin
    if (!hi_hit) begin
      tier = TIER_NONE;
      win  = '0;
    end else if (hi_pick == SIW'(N) && lo_hit) begin
      tier = TIER_LO;
      win  = lo_pick;
    end else begin
      tier = TIER_HI;
      win  = CIW'(hi_pick);
    end
  end

endmodule

// File: rtl/sec_bus_arbiter.sv
// Secondary-side bus arbiter with two priority classes, masking, parking and bypass.
module sec_bus_arbiter
  import sec_arb_pkg::*;
#(
  parameter int unsigned N = ARB_CLIENTS_DFLT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arb_en,
  input  logic [N-1:0] req_n,
  input  logic         frame_n,
  input  logic         irdy_n,
  input  logic [N-1:0] cfg_hi,
  input  logic [N-1:0] cfg_mask,
  input  logic         ext_gnt_n,
  output logic [N-1:0] gnt_n,
  output logic         ext_req_n,
  output logic         host_gnt_n
);
  localparam int unsigned SIW = $clog2(N + 1);
  localparam int unsigned CIW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]   req_q;
  logic           idle_q;
  logic [N-1:0]   gnt_q;
  logic [N-1:0]   gnt_nxt;
  logic [SIW-1:0] hi_ptr;
  logic [CIW-1:0] lo_ptr;
  logic [SIW-1:0] hi_pick;
  logic [CIW-1:0] win;
  tier_e          tier;
  logic           handover;

  sec_arb_sampler #(.N(N)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_n   (req_n),
    .frame_n (frame_n),
    .irdy_n  (irdy_n),
    .req_q   (req_q),
    .idle_q  (idle_q)
  );

  sec_arb_decide #(.N(N)) u_decide (
    .req_q    (req_q),
    .cfg_hi   (cfg_hi),
    .cfg_mask (cfg_mask),
    .hi_ptr   (hi_ptr),
    .lo_ptr   (lo_ptr),
    .tier     (tier),
    .hi_pick  (hi_pick),
    .win      (win)
  );

  // Decision point: nobody holds, holder released, or bus sampled idle
  assign handover = ~|gnt_q | ~|(gnt_q & req_q) | idle_q;

  always_comb begin
    gnt_nxt      = '0;
    gnt_nxt[win] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      hi_ptr <= SIW'(N);
      lo_ptr <= CIW'(N - 1);
    end else if (!arb_en) begin
      gnt_q <= '0;
    end else if (handover) begin
      gnt_q <= gnt_nxt;
      case (tier)
        TIER_HI: hi_ptr <= hi_pick;
        TIER_LO: begin
          hi_ptr <= SIW'(N);
          lo_ptr <= win;
        end
        default: ;
      endcase
    end
  end

  assign gnt_n      = ~gnt_q;
  assign ext_req_n  = arb_en ? 1'b1 : req_n[0];
  assign host_gnt_n = arb_en ? gnt_n[0] : ext_gnt_n;

endmodule

// File: rtl/sec_bus_arbiter_chk.sv
module sec_bus_arbiter_chk #(
  parameter int unsigned N = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         arb_en,
  input logic [N-1:0] cfg_mask,
  input logic [N-1:0] gnt_n,
  input logic [N-1:0] req_q,
  input logic         idle_q
);

  // R3: never two grants
  p_single_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  // R6 / R10: a requesting holder on a busy bus keeps the bus
  p_holder_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && |(~gnt_n & req_q) && !idle_q) |=> (gnt_n == $past(gnt_n)));

  // R8: once enabled, some client always holds a grant
  p_parked_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arb_en |=> $onehot(~gnt_n));

  // R11: disabled arbiter drives every grant high
  p_bypass_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |=> (&gnt_n));

  // R9: a new grant to a non-parking client needs an unmasked sampled request
  for (genvar i = 1; i < N; i++) begin : g_mask
    p_mask_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gnt_n[i]) |-> $past(req_q[i] && !cfg_mask[i]));
  end

endmodule

bind sec_bus_arbiter sec_bus_arbiter_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .arb_en   (arb_en),
  .cfg_mask (cfg_mask),
  .gnt_n    (gnt_n),
  .req_q    (req_q),
  .idle_q   (idle_q)
);

// File: tb/sec_bus_arbiter_tb.sv
module sec_bus_arbiter_tb;
  localparam int unsigned N = 7;
  localparam logic [6:0] HI_DEF = 7'b0000011;
  localparam int NVEC = 20;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         arb_en;
  logic [N-1:0] req_n;
  logic         frame_n;
  logic         irdy_n;
  logic [N-1:0] cfg_hi;
  logic [N-1:0] cfg_mask;
  logic         ext_gnt_n;
  logic [N-1:0] gnt_n;
  logic         ext_req_n;
  logic         host_gnt_n;

  int checks = 0;
  int fails  = 0;
  int multi  = 0;

  always #5 clk = ~clk;

  sec_bus_arbiter #(.N(N)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .arb_en     (arb_en),
    .req_n      (req_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .cfg_hi     (cfg_hi),
    .cfg_mask   (cfg_mask),
    .ext_gnt_n  (ext_gnt_n),
    .gnt_n      (gnt_n),
    .ext_req_n  (ext_req_n),
    .host_gnt_n (host_gnt_n)
  );

  // Fields: request (active high), class, mask, expected grant (active high), requirement number
  localparam logic [35:0] VECS [NVEC] = '{
    {7'b0000000, HI_DEF,     7'b0000000, 7'b0000001, 8'd8},  // R8 park with no request
    {7'b0000100, HI_DEF,     7'b0000000, 7'b0000100, 8'd5},  // R5 low slot, low search from 0
    {7'b0000110, HI_DEF,     7'b0000000, 7'b0000100, 8'd6},  // R6 holder keeps bus
    {7'b0000010, HI_DEF,     7'b0000000, 7'b0000010, 8'd4},  // R4 high client after low slot
    {7'b1011010, HI_DEF,     7'b0000000, 7'b0000010, 8'd6},  // R6 / R3 many requesters, one grant
    {7'b1011000, HI_DEF,     7'b0000000, 7'b0001000, 8'd5},  // R5 low slot after client 1
    {7'b1010001, HI_DEF,     7'b0000000, 7'b0000001, 8'd5},  // R5 high wraps to 0 after low slot
    {7'b1010000, HI_DEF,     7'b0000000, 7'b0010000, 8'd5},  // R5 low rotates past 3 to 4
    {7'b1000011, HI_DEF,     7'b0000000, 7'b0000001, 8'd4},  // R4 client 0 first
    {7'b1000010, HI_DEF,     7'b0000000, 7'b0000010, 8'd4},  // R4 then client 1
    {7'b1000001, HI_DEF,     7'b0000000, 7'b1000000, 8'd5},  // R5 low group not starved
    {7'b0000001, HI_DEF,     7'b0000000, 7'b0000001, 8'd4},  // R4 back to client 0
    {7'b0001000, HI_DEF,     7'b0001000, 7'b0000001, 8'd9},  // R9 masked request ignored
    {7'b0011000, HI_DEF,     7'b0001000, 7'b0010000, 8'd9},  // R9 unmasked neighbour served
    {7'b0011000, HI_DEF,     7'b0010000, 7'b0010000, 8'd10}, // R10 masking the holder keeps it
    {7'b0001000, HI_DEF,     7'b0010000, 7'b0001000, 8'd10}, // R10 new mask used at handover
    {7'b0101000, 7'b0100011, 7'b0000000, 7'b0001000, 8'd10}, // R10 class change keeps holder
    {7'b0100100, 7'b0100011, 7'b0000000, 7'b0100000, 8'd10}, // R10 client 5 now high
    {7'b0000100, 7'b0100011, 7'b0000000, 7'b0000100, 8'd5},  // R5 low client 2
    {7'b0000000, 7'b0100011, 7'b0000000, 7'b0000001, 8'd8}   // R8 park again
  };

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    check("R3", 7'(multi), 7'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    arb_en    = 1'b1;
    req_n     = '1;
    frame_n   = 1'b0;
    irdy_n    = 1'b0;
    cfg_hi    = HI_DEF;
    cfg_mask  = '0;
    ext_gnt_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", gnt_n, 7'b1111111);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", gnt_n, 7'b1111110);
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && $countones(~gnt_n) > 1) multi++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();

    // R2: one sampling stage before the decision
    req_n = ~7'b0000010;
    @(negedge clk);
    check("R2", gnt_n, 7'b1111110);
    @(negedge clk);
    check("R2", gnt_n, 7'b1111101);

    do_reset();
    for (int i = 0; i < NVEC; i++) begin
      req_n    = ~VECS[i][35:29];
      cfg_hi   = VECS[i][28:22];
      cfg_mask = VECS[i][21:15];
      repeat (2) @(negedge clk);
      check($sformatf("R%0d", VECS[i][7:0]), gnt_n, ~VECS[i][14:8]);
    end

    // R7: idle handover needs both signals high
    do_reset();
    req_n = ~7'b0000110;
    repeat (2) @(negedge clk);
    check("R4", gnt_n, 7'b1111101);
    frame_n = 1'b1;
    irdy_n  = 1'b0;
    repeat (3) @(negedge clk);
    check("R7", gnt_n, 7'b1111101);
    irdy_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7", gnt_n, 7'b1111011);
    frame_n = 1'b0;
    irdy_n  = 1'b0;

    // R11: bypass to an external arbiter
    do_reset();
    arb_en    = 1'b0;
    req_n     = ~7'b0000001;
    ext_gnt_n = 1'b0;
    #1;
    check("R11", {6'd0, ext_req_n}, 7'd0);
    check("R11", {6'd0, host_gnt_n}, 7'd0);
    @(negedge clk);
    check("R11", gnt_n, 7'b1111111);
    req_n     = ~7'b0000100;
    ext_gnt_n = 1'b1;
    #1;
    check("R11", {6'd0, ext_req_n}, 7'd1);
    check("R11", {6'd0, host_gnt_n}, 7'd1);
    repeat (2) @(negedge clk);
    check("R11", gnt_n, 7'b1111111);
    arb_en    = 1'b1;
    ext_gnt_n = 1'b0;
    @(negedge clk);
    check("R11", gnt_n, 7'b1111011);
    check("R11", {6'd0, host_gnt_n}, 7'd1);
    check("R11", {6'd0, ext_req_n}, 7'd1);

    finish_run();
  end

endmodule